// File: doc/BRIEF.md
# Processing Element Write-Back Line Controller

This block is the local cache controller of one processing element in a shared-memory machine that merges concurrent updates at global memory. It keeps a small direct-mapped array of lines and marks each one invalid, clean or dirty. It serves CPU reads and writes locally on a hit. On a miss it first evicts the old line and then fetches the block. It also handles uncached (bypass) word accesses and invalidation commands sent by global memory. A synchronization request sweeps the whole array.

Global memory counts how many copies of each block are outstanding, so it must hear about every copy that leaves a cache. A dirty line that leaves sends its full block back as a flush. A clean line that leaves sends a replacement report with no data. All outgoing traffic goes through one message port with a valid/ready handshake, one message at a time. Replies with block or word data come back on a separate reply input.

The CPU address is a word address. The low `log2(WORDS)` bits select the word, the next `log2(LINES)` bits select the line, and the remaining bits form the tag.

Top module: `pe_line_ctrl`

## Requirements
- R1: After reset every line is invalid, `msg_valid`, `cpu_resp_valid` and `sync_done` are low, and `cpu_ready`, `inv_ready` and `sync_ready` are high.
- R2: A read or write miss sends a block request (`msg_kind` 0) carrying the block base address (word offset zero). It waits for `rep_valid` and then installs the block as clean. A read miss returns the addressed word of the reply.
- R3: A read or write hit sends no message and raises `cpu_resp_valid` on the clock edge that accepts the request. A read hit returns the stored word.
- R4: A write hit or write miss leaves the line dirty and holds the new word. A later eviction of that line therefore returns the written value to global memory.
- R5: When a miss replaces a dirty line, a flush (`msg_kind` 1) is sent first. It carries the victim's block base address and its full block on `msg_data`, and the victim becomes invalid.
- R6: When a miss replaces a clean line, a replacement report (`msg_kind` 2) is sent first. It carries the victim's block base address and an all-zero `msg_data`.
- R7: An invalidate on `inv_valid`/`inv_blk` (a block address) for a resident line sends a flush or a report under the same rule as R5/R6, and the line becomes invalid. An invalidate for a block that is not resident sends nothing and leaves the cache unchanged. An invalidate is accepted while a miss or bypass read waits for its reply.
- R8: A bypass read sends `msg_kind` 3 with the word address and returns the low word of the reply. A bypass write sends `msg_kind` 4 with the word address and the data in the low word of `msg_data`. Neither one allocates or changes a line.
- R9: An accepted `sync_req` visits lines from index 0 upward. Each valid line sends a flush or a report and becomes invalid, and invalid lines are skipped. After the last line, `sync_done` pulses for one cycle and the whole cache is invalid.
- R10: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_kind`, `msg_addr` and `msg_data` hold their values.
- R11: In the idle state an invalidate takes priority over a sync request, and a sync request takes priority over a CPU request. `sync_ready` is low while `inv_valid` is high, and `cpu_ready` is low while either `inv_valid` or `sync_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | CPU request present |
| cpu_ready | output | 1 | CPU request accepted this cycle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_bypass | input | 1 | Access global memory directly, no allocation |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with the completion pulse |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Global memory takes the message |
| msg_kind | output | 3 | 0 request, 1 flush, 2 report, 3 bypass read, 4 bypass write |
| msg_addr | output | ADDR_W | Block base or word address |
| msg_data | output | WORDS*DATA_W | Flushed block, or bypass write word in the low bits |
| rep_valid | input | 1 | Reply pulse from global memory |
| rep_data | input | WORDS*DATA_W | Reply block, or word in the low bits |
| inv_valid | input | 1 | Invalidate command present |
| inv_ready | output | 1 | Invalidate command accepted |
| inv_blk | input | ADDR_W-log2(WORDS) | Block address to invalidate |
| sync_req | input | 1 | Request a full-cache sweep |
| sync_ready | output | 1 | Sweep request accepted |
| sync_done | output | 1 | One-cycle pulse after the sweep |

## Verification
A line left in the wrong state shows up at the message port on the next miss to that index. A dirty line wrongly marked clean sends a report instead of a flush, and the bench's global-memory model then loses the written word. A line left valid sends an extra message or returns stale data without any traffic. The stimulus therefore chains misses on each index, so that a state error appears within one or two operations. Sweeps and invalidates are checked message by message against the exact kind, address and order that the bench expects. Handshake faults appear within a cycle as changed message fields during back-pressure.

// File: rtl/pe_line_ctrl.sv
module pe_line_ctrl #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int LINES  = 4,
  parameter int WORDS  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cpu_valid,
  output logic                            cpu_ready,
  input  logic                            cpu_write,
  input  logic                            cpu_bypass,
  input  logic [ADDR_W-1:0]               cpu_addr,
  input  logic [DATA_W-1:0]               cpu_wdata,
  output logic                            cpu_resp_valid,
  output logic [DATA_W-1:0]               cpu_rdata,
  output logic                            msg_valid,
  input  logic                            msg_ready,
  output logic [2:0]                      msg_kind,
  output logic [ADDR_W-1:0]               msg_addr,
  output logic [WORDS*DATA_W-1:0]         msg_data,
  input  logic                            rep_valid,
  input  logic [WORDS*DATA_W-1:0]         rep_data,
  input  logic                            inv_valid,
  output logic                            inv_ready,
  input  logic [ADDR_W-$clog2(WORDS)-1:0] inv_blk,
  input  logic                            sync_req,
  output logic                            sync_ready,
  output logic                            sync_done
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int BLK_W = WORDS * DATA_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);
  localparam logic [2:0] K_REQ = 3'd0, K_FLUSH = 3'd1, K_REPORT = 3'd2, K_BRD = 3'd3, K_BWR = 3'd4;

  typedef enum logic [2:0] {IDLE, EVICT, REQ, WAIT, BYP, INVS, SYNC} st_t;
  st_t st, ret;

  logic [LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [BLK_W-1:0] blk_q [LINES];
  logic             r_write, r_byp;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic [IDX_W-1:0] inv_idx, sw_idx;
  logic             hold_q;
  logic [BLK_W-1:0] hold_blk, fill_blk;

  wire [OFF_W-1:0] c_off = cpu_addr[OFF_W-1:0];
  wire [IDX_W-1:0] c_idx = cpu_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  wire             c_hit = valid_q[c_idx] && tag_q[c_idx] == c_tag;
  wire [OFF_W-1:0] r_off = r_addr[OFF_W-1:0];
  wire [IDX_W-1:0] r_idx = r_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] r_tag = r_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] i_idx = inv_blk[IDX_W-1:0];
  wire [TAG_W-1:0] i_tag = inv_blk[ADDR_W-OFF_W-1 -: TAG_W];
  wire             i_hit = valid_q[i_idx] && tag_q[i_idx] == i_tag;
  wire [IDX_W-1:0] ev_idx = (st == INVS) ? inv_idx : (st == SYNC) ? sw_idx : r_idx;
  wire             idle = (st == IDLE);
  wire             rep_in = rep_valid || hold_q;
  wire [BLK_W-1:0] rep_blk = hold_q ? hold_blk : rep_data;
  wire             take = msg_valid && msg_ready;

  assign inv_ready  = idle || (st == WAIT && !rep_in);
  assign sync_ready = idle && !inv_valid;
  assign cpu_ready  = idle && !inv_valid && !sync_req;

  always_comb begin
    fill_blk = rep_blk;
    if (r_write) fill_blk[r_off*DATA_W +: DATA_W] = r_wdata;
  end

  always_comb begin
    msg_valid = 1'b0;
    msg_kind  = K_REQ;
    msg_addr  = {tag_q[ev_idx], ev_idx, {OFF_W{1'b0}}};
    msg_data  = '0;
    case (st)
      EVICT, INVS, SYNC: begin
        msg_valid = (st != SYNC) || valid_q[sw_idx];
        msg_kind  = dirty_q[ev_idx] ? K_FLUSH : K_REPORT;
        if (dirty_q[ev_idx]) msg_data = blk_q[ev_idx];
      end
      REQ: begin
        msg_valid = 1'b1;
        msg_addr  = {r_tag, r_idx, {OFF_W{1'b0}}};
      end
      BYP: begin
        msg_valid = 1'b1;
        msg_kind  = r_write ? K_BWR : K_BRD;
        msg_addr  = r_addr;
        if (r_write) msg_data = {{(BLK_W-DATA_W){1'b0}}, r_wdata};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ret <= IDLE;
      valid_q <= '0; dirty_q <= '0;
      r_write <= 1'b0; r_byp <= 1'b0; r_addr <= '0; r_wdata <= '0;
      inv_idx <= '0; sw_idx <= '0;
      hold_q <= 1'b0; hold_blk <= '0;
      cpu_resp_valid <= 1'b0; cpu_rdata <= '0; sync_done <= 1'b0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        blk_q[i] <= '0;
      end
    end else begin
      cpu_resp_valid <= 1'b0;
      sync_done <= 1'b0;
      if (rep_valid && st != WAIT) begin
        hold_q <= 1'b1;
        hold_blk <= rep_data;
      end
      case (st)
        IDLE:
          if (inv_valid) begin
            if (i_hit) begin inv_idx <= i_idx; ret <= IDLE; st <= INVS; end
          end else if (sync_req) begin
            sw_idx <= '0; st <= SYNC;
          end else if (cpu_valid) begin
            r_write <= cpu_write; r_byp <= cpu_bypass; r_addr <= cpu_addr; r_wdata <= cpu_wdata;
            if (cpu_bypass) st <= BYP;
            else if (c_hit) begin
              cpu_resp_valid <= 1'b1;
              if (cpu_write) begin
                blk_q[c_idx][c_off*DATA_W +: DATA_W] <= cpu_wdata;
                dirty_q[c_idx] <= 1'b1;
              end else cpu_rdata <= blk_q[c_idx][c_off*DATA_W +: DATA_W];
            end else st <= valid_q[c_idx] ? EVICT : REQ;
          end
        EVICT: if (take) begin valid_q[r_idx] <= 1'b0; dirty_q[r_idx] <= 1'b0; st <= REQ; end
        REQ:   if (take) st <= WAIT;
        BYP:   if (take) begin
                 if (r_write) begin cpu_resp_valid <= 1'b1; st <= IDLE; end
                 else st <= WAIT;
               end
        WAIT:
          if (rep_in) begin
            hold_q <= 1'b0;
            cpu_resp_valid <= 1'b1;
            st <= IDLE;
            if (r_byp) cpu_rdata <= rep_blk[DATA_W-1:0];
            else begin
              valid_q[r_idx] <= 1'b1;
              dirty_q[r_idx] <= r_write;
              tag_q[r_idx] <= r_tag;
              blk_q[r_idx] <= fill_blk;
              cpu_rdata <= rep_blk[r_off*DATA_W +: DATA_W];
            end
          end else if (inv_valid && i_hit) begin
            inv_idx <= i_idx; ret <= WAIT; st <= INVS;
          end
        INVS: if (take) begin valid_q[inv_idx] <= 1'b0; dirty_q[inv_idx] <= 1'b0; st <= ret; end
        SYNC:
          if (!valid_q[sw_idx] || msg_ready) begin
            valid_q[sw_idx] <= 1'b0;
            dirty_q[sw_idx] <= 1'b0;
            if (sw_idx == LAST) begin st <= IDLE; sync_done <= 1'b1; end
            else sw_idx <= sw_idx + 1'b1;
          end
        default: st <= IDLE;
      endcase
    end
  end

  p_block_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_kind != K_BRD && msg_kind != K_BWR |-> msg_addr[OFF_W-1:0] == '0);
  p_hit_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_ready && !cpu_bypass && c_hit |=> !msg_valid && cpu_resp_valid);
  p_write_dirty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_ready && !cpu_bypass && c_hit && cpu_write |=> dirty_q[$past(c_idx)]);
  p_bypass_noalloc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_ready && cpu_bypass |=> $stable(valid_q));
  p_sweep_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |-> valid_q == '0);
  p_msg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) && $stable(msg_addr) && $stable(msg_data));
endmodule

// File: tb/sim_pe_line_ctrl.sv
`timescale 1ns/1ps
module sim_pe_line_ctrl;
  logic clk = 0, rst_n = 0;
  logic cpu_valid = 0, cpu_write = 0, cpu_bypass = 0;
  logic [9:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic cpu_ready, cpu_resp_valid;
  logic [15:0] cpu_rdata;
  logic msg_valid, msg_ready = 1;
  logic [2:0] msg_kind;
  logic [9:0] msg_addr;
  logic [63:0] msg_data;
  logic rep_valid = 0;
  logic [63:0] rep_data = '0;
  logic inv_valid = 0, inv_ready;
  logic [7:0] inv_blk = '0;
  logic sync_req = 0, sync_ready, sync_done;

  always #10 clk = ~clk;

  pe_line_ctrl u0 (.clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_write(cpu_write), .cpu_bypass(cpu_bypass), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_resp_valid(cpu_resp_valid), .cpu_rdata(cpu_rdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_kind(msg_kind), .msg_addr(msg_addr), .msg_data(msg_data),
    .rep_valid(rep_valid), .rep_data(rep_data), .inv_valid(inv_valid), .inv_ready(inv_ready),
    .inv_blk(inv_blk), .sync_req(sync_req), .sync_ready(sync_ready), .sync_done(sync_done));

  int total = 0, fails = 0;
  int log_n = 0, bad_align = 0, bad_report = 0, rep_cnt = 0, rep_delay = 2, done_cnt = 0;
  logic stall = 0;
  logic [2:0] log_kind [64];
  logic [9:0] log_addr [64];
  logic [63:0] log_data [64];
  logic [63:0] pend = '0;
  logic [15:0] mem [1024];
  logic [15:0] shadow [1024];

  function automatic logic [15:0] init_val(input int a);
    return 16'((a * 16'h0101) ^ 16'h5A5A);
  endfunction

  initial for (int a = 0; a < 1024; a++) begin mem[a] = init_val(a); shadow[a] = init_val(a); end

  always @(negedge clk) begin
    if (rep_cnt == 1) begin rep_valid = 1; rep_data = pend; end
    else rep_valid = 0;
    if (rep_cnt > 0) rep_cnt--;
    msg_ready = !stall;
    if (sync_done) done_cnt++;
    if (rst_n && msg_valid && !stall) begin
      log_kind[log_n % 64] = msg_kind;
      log_addr[log_n % 64] = msg_addr;
      log_data[log_n % 64] = msg_data;
      log_n++;
      case (msg_kind)
        3'd0: begin
          for (int w = 0; w < 4; w++) pend[w*16 +: 16] = mem[msg_addr + w];
          rep_cnt = rep_delay;
          if (msg_addr[1:0] != 0) bad_align++;
        end
        3'd1: begin
          for (int w = 0; w < 4; w++) mem[msg_addr + w] = msg_data[w*16 +: 16];
          if (msg_addr[1:0] != 0) bad_align++;
        end
        3'd2: begin
          if (msg_data != 0) bad_report++;
          if (msg_addr[1:0] != 0) bad_align++;
        end
        3'd3: begin pend = {48'h0, mem[msg_addr]}; rep_cnt = rep_delay; end
        3'd4: mem[msg_addr] = msg_data[15:0];
        default: bad_align++;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
  endtask

  task automatic chk_log(input string req, input int i, input logic [2:0] k, input logic [9:0] a);
    chk(req, $sformatf("log[%0d] kind", i), 64'(log_kind[i % 64]), 64'(k));
    chk(req, $sformatf("log[%0d] addr", i), 64'(log_addr[i % 64]), 64'(a));
  endtask

  task automatic do_op(input logic wr, input logic byp, input logic [9:0] a, input logic [15:0] d,
                       output logic [15:0] rd, output int wc);
    @(negedge clk);
    cpu_valid = 1; cpu_write = wr; cpu_bypass = byp; cpu_addr = a; cpu_wdata = d;
    #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cpu_valid = 0;
    wc = 0;
    while (!cpu_resp_valid && wc < 200) begin @(posedge clk); #1; wc++; end
    rd = cpu_rdata;
    if (wr) shadow[a] = d;
  endtask

  task automatic inv_cmd(input logic [9:0] a);
    @(negedge clk);
    inv_valid = 1; inv_blk = a[9:2];
    #1;
    while (!inv_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    inv_valid = 0;
    repeat (4) @(posedge clk);
  endtask

  // wr, byp, addr, wdata, message count, first kind (7 = none)
  localparam logic [33:0] VEC [14] = '{
    {1'b0, 1'b0, 10'h010, 16'h0000, 3'd1, 3'd0},
    {1'b0, 1'b0, 10'h011, 16'h0000, 3'd0, 3'd7},
    {1'b1, 1'b0, 10'h012, 16'hAAAA, 3'd0, 3'd7},
    {1'b0, 1'b0, 10'h012, 16'h0000, 3'd0, 3'd7},
    {1'b0, 1'b0, 10'h020, 16'h0000, 3'd2, 3'd1},
    {1'b0, 1'b0, 10'h030, 16'h0000, 3'd2, 3'd2},
    {1'b1, 1'b0, 10'h044, 16'h1234, 3'd1, 3'd0},
    {1'b0, 1'b0, 10'h044, 16'h0000, 3'd0, 3'd7},
    {1'b0, 1'b1, 10'h012, 16'h0000, 3'd1, 3'd3},
    {1'b1, 1'b1, 10'h100, 16'h5555, 3'd1, 3'd4},
    {1'b0, 1'b0, 10'h100, 16'h0000, 3'd2, 3'd2},
    {1'b1, 1'b0, 10'h04F, 16'hBEEF, 3'd1, 3'd0},
    {1'b0, 1'b0, 10'h08F, 16'h0000, 3'd2, 3'd1},
    {1'b0, 1'b0, 10'h04F, 16'h0000, 3'd2, 3'd2}
  };

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd0: return "R2";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3, 3'd4: return "R8";
      default: return "R3";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int wc, l0, dc;
    logic op_done;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "msg_valid in reset", 64'(msg_valid), 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1", "cpu_ready", 64'(cpu_ready), 1);
    chk("R1", "inv_ready", 64'(inv_ready), 1);
    chk("R1", "sync_ready", 64'(sync_ready), 1);
    chk("R1", "msg_valid", 64'(msg_valid), 0);
    chk("R1", "resp/done", 64'({cpu_resp_valid, sync_done}), 0);

    for (int v = 0; v < 14; v++) begin
      logic [33:0] e;
      e = VEC[v];
      l0 = log_n;
      do_op(e[33], e[32], e[31:22], e[21:6], rd, wc);
      chk(tag_of(e[2:0]), $sformatf("vec %0d message count", v), 64'(log_n - l0), 64'(e[5:3]));
      if (e[5:3] != 0) chk(tag_of(e[2:0]), $sformatf("vec %0d first kind", v), 64'(log_kind[l0 % 64]), 64'(e[2:0]));
      else chk("R3", $sformatf("vec %0d hit latency", v), 64'(wc), 0);
      if (!e[33]) chk(e[5:3] == 0 ? "R3" : tag_of(e[2:0]), $sformatf("vec %0d rdata", v), 64'(rd), 64'(shadow[e[31:22]]));
    end
    chk("R4", "dirty word flushed to memory", 64'(mem[10'h012]), 64'hAAAA);
    chk("R4", "second dirty word flushed", 64'(mem[10'h04F]), 64'hBEEF);

    // R7: invalidate that misses does nothing
    l0 = log_n;
    inv_cmd(10'h200);
    chk("R7", "no message for absent block", 64'(log_n - l0), 0);
    do_op(0, 0, 10'h100, 0, rd, wc);
    chk("R7", "line kept after absent invalidate", 64'(log_n - l0), 0);
    chk("R7", "rdata kept line", 64'(rd), 64'h5555);

    // R7: invalidate of dirty resident line
    do_op(1, 0, 10'h045, 16'h3C3C, rd, wc);
    l0 = log_n;
    inv_cmd(10'h044);
    chk("R7", "one message", 64'(log_n - l0), 1);
    chk_log("R7", l0, 3'd1, 10'h044);
    chk("R7", "flushed word", 64'(log_data[l0 % 64][31:16]), 64'h3C3C);
    do_op(0, 0, 10'h044, 0, rd, wc);
    chk_log("R7", l0 + 1, 3'd0, 10'h044);
    chk("R7", "refetched word", 64'(rd), 64'h1234);

    // R7: invalidate accepted while waiting for a block reply
    rep_delay = 8;
    op_done = 0;
    l0 = log_n;
    fork
      begin do_op(0, 0, 10'h0A8, 0, rd, wc); op_done = 1; end
      begin
        repeat (4) @(posedge clk);
        inv_cmd(10'h100);
        chk("R7", "report sent before miss completed", 64'(log_n - l0), 2);
      end
    join
    rep_delay = 2;
    chk_log("R2", l0, 3'd0, 10'h0A8);
    chk_log("R7", l0 + 1, 3'd2, 10'h100);
    chk("R7", "miss data after invalidate", 64'(rd), 64'(shadow[10'h0A8]));

    // R9: full sweep in index order
    do_op(1, 0, 10'h300, 16'h7777, rd, wc);
    l0 = log_n;
    dc = done_cnt;
    @(negedge clk); sync_req = 1; #1;
    while (!sync_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1; sync_req = 0;
    repeat (12) @(posedge clk);
    chk("R9", "sweep message count", 64'(log_n - l0), 4);
    chk_log("R9", l0,     3'd1, 10'h300);
    chk_log("R9", l0 + 1, 3'd2, 10'h044);
    chk_log("R9", l0 + 2, 3'd2, 10'h0A8);
    chk_log("R9", l0 + 3, 3'd2, 10'h04C);
    chk("R9", "done pulses", 64'(done_cnt - dc), 1);
    chk("R9", "flushed sweep word", 64'(mem[10'h300]), 64'h7777);
    l0 = log_n;
    do_op(0, 0, 10'h044, 0, rd, wc);
    chk("R9", "line invalid after sweep", 64'(log_n - l0), 1);

    // R10 / R8: back-pressure on a bypass write
    @(posedge clk); #1;
    stall = 1;
    l0 = log_n;
    fork
      do_op(1, 1, 10'h123, 16'h4242, rd, wc);
      begin
        repeat (3) @(posedge clk); #1;
        chk("R8", "bypass write kind", 64'(msg_kind), 4);
        chk("R8", "bypass write data", 64'(msg_data), 64'h4242);
        repeat (2) @(posedge clk); #1;
        chk("R10", "valid held", 64'(msg_valid), 1);
        chk("R10", "addr held", 64'(msg_addr), 64'h123);
        chk("R10", "no completion while stalled", 64'(cpu_resp_valid), 0);
        stall = 0;
      end
    join
    chk("R8", "bypass write reached memory", 64'(mem[10'h123]), 64'h4242);
    chk("R8", "one bypass message", 64'(log_n - l0), 1);

    // R11: priority among invalidate, sweep and CPU
    l0 = log_n;
    dc = done_cnt;
    @(negedge clk);
    inv_valid = 1; inv_blk = 8'h11; sync_req = 1;
    cpu_valid = 1; cpu_write = 0; cpu_bypass = 0; cpu_addr = 10'h044;
    #1;
    chk("R11", "inv_ready", 64'(inv_ready), 1);
    chk("R11", "sync_ready blocked", 64'(sync_ready), 0);
    chk("R11", "cpu_ready blocked", 64'(cpu_ready), 0);
    @(posedge clk); #1; inv_valid = 0;
    @(negedge clk); #1;
    while (!sync_ready) begin @(negedge clk); #1; end
    chk("R11", "cpu waits behind sweep", 64'(cpu_ready), 0);
    @(posedge clk); #1; sync_req = 0;
    @(negedge clk); #1;
    while (!cpu_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1; cpu_valid = 0;
    wc = 0;
    while (!cpu_resp_valid && wc < 200) begin @(posedge clk); #1; wc++; end
    chk("R11", "cpu read data", 64'(cpu_rdata), 64'(shadow[10'h044]));
    chk("R11", "message count", 64'(log_n - l0), 2);
    chk_log("R11", l0, 3'd2, 10'h044);
    chk_log("R11", l0 + 1, 3'd0, 10'h044);
    chk("R11", "sweep ran before cpu", 64'(done_cnt - dc), 1);

    chk("R2", "block messages aligned", 64'(bad_align), 0);
    chk("R6", "reports carry no data", 64'(bad_report), 0);
    summary();
    $finish;
  end
endmodule